// File: doc/BRIEF.md
# Comma-Spaced Link Lock and Payload Error Checker

This block sits behind a deserializer and 8b/10b decoder. Each cycle it may receive one decoded byte, which comes with a valid strobe and a flag marking a control comma character. The far end sends a comma once in every 64 words. Between commas it sends payload bytes taken from a 7-bit pseudo-random sequence. The block watches the comma spacing. It declares the link locked only after a first comma and then three more commas, each arriving exactly 64 words after the one before. While the block is still searching, it asks the receiver to realign to commas.

Once locked, the block checks every payload byte against its own copy of the pseudo-random sequence. After each comma, the first payload byte reseeds this local copy, so the checker resynchronises by itself. Every later byte is compared bit by bit with the local copy. The number of differing bits is added to a saturating error count.

If a comma comes early, or no comma comes where one is due, the block drops lock and returns to searching.

Top module: `comma_lock_checker`

## Requirements
- R1: After reset, `locked` is 0, `realign_req` is 1 and `bit_errs` is 0.
- R2: A comma seen while searching starts a run. A word counts as one of the 64 words only when `in_valid` is 1. A comma that arrives after exactly 63 valid non-comma words is a correct one. `locked` rises in the cycle after the third correct comma that follows the first, so four commas in total are needed.
- R3: In the verify or locked state, a comma that arrives after fewer than 63 non-comma words returns the block to searching. The count of correct commas is cleared, and that comma does not start a new run. `locked` falls in the next cycle.
- R4: In the verify or locked state, a non-comma word arriving in the slot where a comma is due (the 64th word after the last comma) returns the block to searching. `locked` falls in the next cycle.
- R5: `realign_req` is always the complement of `locked`.
- R6: Cycles with `in_valid` low change neither the state, the word position nor the error count, whatever `in_data` and `in_comma` carry.
- R7: The first non-comma word after each comma seeds the local sequence state with `in_data[6:0]`. That word is not checked.
- R8: The local sequence uses x^7+x^6+1. The feedback bit is state[6] XOR state[5] and is shifted in at state[0]. Each payload word is the next 8 feedback bits, with the first one in bit 7.
- R9: A checked word is a non-comma word that arrives while locked and is neither the seed word nor the word in the due-comma slot. For each checked word, `bit_errs` grows by the number of bits where `in_data` differs from the expected word. The new value shows in the cycle after the word.
- R10: `bit_errs` saturates at 2^ERR_W-1 and stays there.
- R11: Words received while not locked add nothing to `bit_errs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W (8) | Decoded byte |
| in_comma | input | 1 | Byte is a comma control character |
| in_valid | input | 1 | Byte strobe |
| locked | output | 1 | Comma spacing verified, payload being checked |
| realign_req | output | 1 | Request to the receiver to realign to commas |
| bit_errs | output | ERR_W (16) | Saturating count of payload bit errors |

## Verification
The interesting coincidence is a corrupted payload byte that lands in the same cycle as a loss of lock. The bench provokes it by sending a byte with all bits flipped in the slot where a comma is due. That byte both breaks the lock and would count as eight errors if it were checked. The expected result is that `locked` falls in the next cycle and `bit_errs` does not change.

Saturation is handled in a similar way. The bench drives the count past its ceiling inside one frame with a narrow ERR_W, then sends a further error and expects the count to hold at its maximum.

// File: rtl/cl_pkg.sv
package cl_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } lock_state_t;
endpackage

// File: rtl/cl_lock_fsm.sv
module cl_lock_fsm
  import cl_pkg::*;
#(
  parameter int SPACING     = 64,
  parameter int LOCK_COMMAS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_comma,
  output logic locked,
  output logic realign_req,
  output logic chk_window
);
  localparam int POS_W = $clog2(SPACING);
  localparam int CNT_W = $clog2(LOCK_COMMAS + 1);
  localparam logic [POS_W-1:0] SLOT = POS_W'(SPACING - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_COMMAS - 1);

  lock_state_t state_q, state_n;
  logic [POS_W-1:0] pos_q, pos_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic at_slot, misplaced;

  assign at_slot   = (pos_q == SLOT);
  assign misplaced = in_valid && (in_comma != at_slot);

  always_comb begin
    state_n = state_q;
    pos_n   = pos_q;
    cnt_n   = cnt_q;
    if (in_valid) begin
      if (state_q == ST_SEARCH) begin
        if (in_comma) begin
          state_n = ST_VERIFY;
          pos_n   = '0;
          cnt_n   = '0;
        end
      end else if (misplaced) begin
        state_n = ST_SEARCH;
        pos_n   = '0;
        cnt_n   = '0;
      end else if (in_comma) begin
        pos_n = '0;
        if (state_q == ST_VERIFY) begin
          if (cnt_q == LAST) state_n = ST_LOCKED;
          else               cnt_n   = cnt_q + 1'b1;
        end
      end else begin
        pos_n = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_SEARCH;
      pos_q       <= '0;
      cnt_q       <= '0;
      locked      <= 1'b0;
      realign_req <= 1'b1;
    end else begin
      state_q     <= state_n;
      pos_q       <= pos_n;
      cnt_q       <= cnt_n;
      locked      <= (state_n == ST_LOCKED);
      realign_req <= (state_n != ST_LOCKED);
    end
  end

  assign chk_window = (state_q == ST_LOCKED) && !at_slot;

  // R2: lock is only ever gained on a comma
  assert_lock_on_comma_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(in_valid && in_comma));
  // R3: early comma while locked drops lock
  assert_early_comma_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (locked && in_valid && in_comma && !at_slot) |=> !locked);
  // R4: missing comma while locked drops lock
  assert_missing_comma_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (locked && in_valid && !in_comma && at_slot) |=> !locked);
  // R5: realign request mirrors lock
  assert_realign_inverse_R5: assert property (@(posedge clk) disable iff (rst)
    locked != realign_req);
  // R6: idle cycles leave lock and position untouched
  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(locked) && $stable(pos_q)));
endmodule

// File: rtl/cl_prbs_ref.sv
module cl_prbs_ref #(
  parameter int DATA_W = 8,
  parameter int PRBS_W = 7,
  parameter int TAP_A  = 6,
  parameter int TAP_B  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_comma,
  input  logic [DATA_W-1:0] in_data,
  input  logic              chk_window,
  output logic              cmp_en,
  output logic [DATA_W-1:0] diff
);
  logic [PRBS_W-1:0] ref_q, ref_next, walk;
  logic [DATA_W-1:0] exp_word;
  logic              seeded_q, fb;

  always_comb begin
    walk = ref_q;
    fb   = 1'b0;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      fb          = walk[TAP_A] ^ walk[TAP_B];
      exp_word[b] = fb;
      walk        = {walk[PRBS_W-2:0], fb};
    end
    ref_next = walk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q    <= '0;
      seeded_q <= 1'b0;
    end else if (in_valid) begin
      if (in_comma) begin
        seeded_q <= 1'b0;
      end else if (!seeded_q) begin
        ref_q    <= in_data[PRBS_W-1:0];
        seeded_q <= 1'b1;
      end else begin
        ref_q <= ref_next;
      end
    end
  end

  assign cmp_en = in_valid && !in_comma && seeded_q && chk_window;
  assign diff   = in_data ^ exp_word;

  // R7: a comma leaves the reference unseeded
  assert_comma_unseeds_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_comma) |=> !seeded_q);
  // R7: seed word loads the state
  assert_seed_load_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_comma && !seeded_q) |=> (seeded_q && ref_q == $past(in_data[PRBS_W-1:0])));
endmodule

// File: rtl/cl_err_counter.sv
module cl_err_counter #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_en,
  input  logic [DATA_W-1:0] diff,
  output logic [ERR_W-1:0]  bit_errs
);
  localparam int ONES_W = $clog2(DATA_W + 1);
  localparam logic [ERR_W-1:0] MAXV = '1;

  logic [ONES_W-1:0] ones;
  logic [ERR_W:0]    sum;

  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++) ones = ones + ONES_W'(diff[i]);
    sum = {1'b0, bit_errs} + (ERR_W + 1)'(ones);
  end

  always_ff @(posedge clk) begin
    if (rst)         bit_errs <= '0;
    else if (cmp_en) bit_errs <= sum[ERR_W] ? MAXV : sum[ERR_W-1:0];
  end

  // R10: ceiling is sticky
  assert_saturate_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (bit_errs == MAXV) |=> (bit_errs == MAXV));
  // R9: count only moves on a checked word
  assert_count_gated_R9: assert property (@(posedge clk) disable iff (rst)
    !cmp_en |=> $stable(bit_errs));
  // R9: count never decreases
  assert_count_monotonic_R9: assert property (@(posedge clk) disable iff (rst)
    bit_errs >= $past(bit_errs));
endmodule

// File: rtl/comma_lock_checker.sv
module comma_lock_checker #(
  parameter int DATA_W      = 8,
  parameter int SPACING     = 64,
  parameter int LOCK_COMMAS = 3,
  parameter int PRBS_W      = 7,
  parameter int ERR_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_comma,
  input  logic              in_valid,
  output logic              locked,
  output logic              realign_req,
  output logic [ERR_W-1:0]  bit_errs
);
  logic              chk_window, cmp_en;
  logic [DATA_W-1:0] diff;

  cl_lock_fsm #(.SPACING(SPACING), .LOCK_COMMAS(LOCK_COMMAS)) u_fsm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_comma(in_comma),
    .locked(locked), .realign_req(realign_req), .chk_window(chk_window)
  );

  cl_prbs_ref #(.DATA_W(DATA_W), .PRBS_W(PRBS_W), .TAP_A(PRBS_W - 1), .TAP_B(PRBS_W - 2)) u_ref (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_comma(in_comma),
    .in_data(in_data), .chk_window(chk_window), .cmp_en(cmp_en), .diff(diff)
  );

  cl_err_counter #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_cnt (
    .clk(clk), .rst(rst), .cmp_en(cmp_en), .diff(diff), .bit_errs(bit_errs)
  );

  // R11: no count change unless lock was held
  assert_no_count_unlocked_R11: assert property (@(posedge clk) disable iff (rst)
    !locked |=> $stable(bit_errs));
endmodule

// File: tb/comma_lock_checker_test.sv
module comma_lock_checker_test;
  localparam int EW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    in_data = '0;
  logic          in_comma = 1'b0;
  logic          in_valid = 1'b0;
  logic          locked, realign_req;
  logic [EW-1:0] bit_errs;

  always #4 clk = ~clk;

  comma_lock_checker #(.ERR_W(EW)) uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_comma(in_comma), .in_valid(in_valid),
    .locked(locked), .realign_req(realign_req), .bit_errs(bit_errs)
  );

  typedef struct {
    logic          al;
    logic [EW-1:0] err;
    string         tag;
  } exp_t;

  exp_t     sb[$];
  int       n_chk = 0, n_fail = 0;
  int       run = 0;
  bit       prev_ok = 1'b1;
  int       exp_err = 0;
  logic [6:0] gen = 7'h5A;
  bit       done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_test;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [7:0] next_byte();
    logic [7:0] b;
    for (int k = 7; k >= 0; k--) begin
      b[k] = gen[6] ^ gen[5];
      gen  = {gen[5:0], b[k]};
    end
    return b;
  endfunction

  task automatic send(input logic [7:0] d, input logic c, input string tag);
    exp_t e;
    @(posedge clk); #2;
    in_data = d; in_comma = c; in_valid = 1'b1;
    e.al = (run >= 4); e.err = EW'(exp_err); e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #2;
      in_valid = 1'b0; in_comma = 1'b1; in_data = 8'hA5;
    end
  endtask

  // one comma followed by paylen payload words
  task automatic frame(input int paylen, input int flip_j, input logic [7:0] mask,
                       input bit flip_all, input int gap_j);
    if (run == 0)     run = 1;                 // R2 first comma
    else if (prev_ok) run = run + 1;           // R2 spaced comma
    else              run = 0;                 // R3 early comma
    send(8'hBC, 1'b1, "R2/R3 comma");
    for (int j = 1; j <= paylen; j++) begin
      logic [7:0] m;
      m = ((flip_all && j >= 2) || j == flip_j) ? mask : 8'h00;
      if (run >= 4 && j >= 2 && j <= 63) begin // R9 checked word
        exp_err = exp_err + $countones(m);
        if (exp_err > (1 << EW) - 1) exp_err = (1 << EW) - 1; // R10
      end
      if (j == 64) run = 0;                    // R4 missing comma
      send(next_byte() ^ m, 1'b0, "R9/R11 payload");
      if (j == gap_j) idle(3);                 // R6
    end
    prev_ok = (paylen == 63);
  endtask

  // monitor: pops one expectation for each accepted word
  initial begin
    forever begin
      @(posedge clk);
      if (!rst && in_valid) begin
        exp_t e;
        @(negedge clk);
        if (sb.size() == 0) begin
          check(1'b0, "scoreboard empty", 0, 1);
        end else begin
          e = sb.pop_front();
          check(locked == e.al, {e.tag, " locked"}, int'(locked), int'(e.al));
          check(realign_req == !e.al, "R5 realign_req", int'(realign_req), int'(!e.al));
          check(bit_errs == e.err, {e.tag, " bit_errs"}, int'(bit_errs), int'(e.err));
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      finish_test();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(locked == 1'b0, "R1 locked", int'(locked), 0);
    check(realign_req == 1'b1, "R1 realign_req", int'(realign_req), 1);
    check(bit_errs == '0, "R1 bit_errs", int'(bit_errs), 0);
    idle(5);
    @(negedge clk);
    check(locked == 1'b0, "R6 idle comma ignored", int'(locked), 0);

    frame(63, 10, 8'hFF, 0, 0);     // R11 errors while searching
    frame(63, 0, 8'h00, 0, 20);     // R6 gap inside spacing
    frame(63, 12, 8'h33, 0, 0);     // R11 still verifying
    frame(63, 5, 8'h01, 0, 0);      // R2 lock, R9 +1
    frame(63, 2, 8'h0F, 0, 30);     // R7/R8 first checked word, R6 gap while locked
    frame(63, 63, 8'h80, 0, 0);     // R9 last checked word
    frame(40, 0, 8'h00, 0, 0);      // R3 short frame
    frame(63, 9, 8'hF0, 0, 0);      // R3 drop at early comma, R11
    frame(63, 0, 8'h00, 0, 0);
    frame(10, 0, 8'h00, 0, 0);      // R3 early comma during verify
    frame(63, 0, 8'h00, 0, 0);
    frame(63, 0, 8'h00, 0, 0);
    frame(63, 0, 8'h00, 0, 0);
    frame(63, 0, 8'h00, 0, 0);
    frame(63, 0, 8'h00, 0, 0);      // R2 relock
    frame(63, 20, 8'h11, 0, 0);     // R9 +2
    frame(70, 64, 8'hFF, 0, 0);     // R4 missing comma with corrupt slot word
    frame(63, 0, 8'h00, 0, 0);
    frame(63, 0, 8'h00, 0, 0);
    frame(63, 0, 8'h00, 0, 0);
    frame(63, 0, 8'h00, 0, 0);      // R2 relock
    frame(63, 0, 8'hFF, 1, 0);      // R10 saturate
    frame(63, 7, 8'h01, 0, 0);      // R10 hold
    frame(63, 0, 8'h00, 0, 0);
    idle(4);
    @(negedge clk);
    check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    done = 1'b1;
    finish_test();
  end
endmodule